// File: doc/BRIEF.md
# Chained Hash Bucket Delete Engine

This block removes keys from a hash table that resolves collisions with linked lists. It holds no table storage itself. It reads and writes an external bucket-head table and an external node table, and it returns freed node slots to an external free-slot allocator. Each delete command carries a key and the bucket index that hashing has already computed.

For each command, the engine reads the bucket's head entry and then follows the chain one node at a time. When it finds the key, it unlinks that node. A node at the front of the chain is unlinked by rewriting the head entry. Any other node is unlinked by rewriting its predecessor, using a copy of the predecessor that was saved in registers during the walk. The engine then zero-fills the removed node and hands its slot back. Each command ends with one result, which holds a pass/fail code and the position in the chain where the walk ended.

Both tables are synchronous RAMs with a read latency of one cycle. A write to either table uses the address that is presented in the same cycle as the write enable.

Top module: `chain_delete_engine`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. From the next cycle, `cmd_ready` stays low until the cycle after the result.
- R2: Each accepted command produces exactly one cycle with `res_valid` high. `res_key` equals the accepted key during that cycle.
- R3: If the bucket's head entry has its valid bit at 0, the result is `res_code`=1 (absent) with `res_pos`=0 (no chain). No table write is made and no slot is freed.
- R4: If the walk reaches a node whose next-valid bit is 0 and no node matched, the result is `res_code`=1 with `res_pos`=4 (end of chain, no match). No table write is made and no slot is freed.
- R5: If the first node of the chain matches, the head entry is rewritten with that node's next pointer and next-valid bit. If the node was the only one, the head valid bit becomes 0 and the pointer becomes 0. `res_pos` is 1 (head). This position takes priority over the tail position when the first node is also the last.
- R6: If a node matches that is neither first nor last, its predecessor is rewritten with the predecessor's own key and value, the matched node's next pointer, and next-valid 1. `res_pos` is 2 (middle).
- R7: If the last node of a chain that has two or more nodes matches, its predecessor is rewritten with its own key and value, next pointer 0, and next-valid 0. `res_pos` is 3 (tail).
- R8: The node rewritten in R6 and R7 is always the one that links directly to the match, at any chain depth. All other nodes of the chain keep their contents and order.
- R9: On a match, the cycle after the unlink write writes the matched slot as all zeros (key, value, next pointer, next-valid). In the same cycle, `free_valid` is high with `free_ptr` equal to that slot, and the result is given with `res_code`=0 (removed). A successful delete makes exactly two table writes.

Positions are encoded as 0 = no chain, 1 = head, 2 = middle, 3 = tail, 4 = end of chain without a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Delete command present |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_key | input | KEY_W | Key to remove |
| cmd_bucket | input | BKT_W | Bucket index of the key |
| head_rd_en | output | 1 | Head table read strobe |
| head_addr | output | BKT_W | Head table address for reads and writes |
| head_rd_ptr | input | PTR_W | First-node pointer read from the head table |
| head_rd_vld | input | 1 | Pointer valid bit read from the head table |
| head_wr_en | output | 1 | Head table write strobe |
| head_wr_ptr | output | PTR_W | First-node pointer to write |
| head_wr_vld | output | 1 | Pointer valid bit to write |
| node_rd_en | output | 1 | Node table read strobe |
| node_rd_addr | output | PTR_W | Node table read address |
| node_rd_key | input | KEY_W | Key of the node that was read |
| node_rd_val | input | VAL_W | Value of the node that was read |
| node_rd_next | input | PTR_W | Next pointer of the node that was read |
| node_rd_nvld | input | 1 | Next-valid bit of the node that was read |
| node_wr_en | output | 1 | Node table write strobe |
| node_wr_addr | output | PTR_W | Node table write address |
| node_wr_key | output | KEY_W | Key to write |
| node_wr_val | output | VAL_W | Value to write |
| node_wr_next | output | PTR_W | Next pointer to write |
| node_wr_nvld | output | 1 | Next-valid bit to write |
| free_valid | output | 1 | A slot is being released |
| free_ptr | output | PTR_W | The slot being released |
| res_valid | output | 1 | Result present |
| res_code | output | 1 | 0 = removed, 1 = absent |
| res_pos | output | 3 | Chain position where the walk ended |
| res_key | output | KEY_W | Key of the command this result answers |

## Verification
The assertions check the properties that hold on every cycle:
- `cmd_ready` drops after an accept, and commands never overlap their results.
- An absent result never writes or frees anything.
- A head rewrite or a predecessor rewrite is always followed by the zero-fill of the freed slot, and that zero-fill is paired with the release of the same slot.
- A middle unlink keeps next-valid set, and a tail unlink clears it.

Other properties depend on the contents of the tables, and only the bench's scenarios can show them. These are:
- that the correct predecessor was patched deep in a long chain;
- that the neighbours kept their keys and values;
- that the rebuilt chain matches a reference list after long runs of random deletes, mixed with refills of nearly full buckets.

// File: rtl/chain_del_pkg.sv
package chain_del_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEADCHK,
        ST_WALK,
        ST_CUT_HEAD,
        ST_CUT_MID,
        ST_CUT_TAIL,
        ST_NOHEAD,
        ST_MISS,
        ST_WIPE
    } del_state_e;

    typedef enum logic [2:0] {
        POS_NONE = 3'd0,
        POS_HEAD = 3'd1,
        POS_MID  = 3'd2,
        POS_TAIL = 3'd3,
        POS_MISS = 3'd4
    } del_pos_e;

    typedef enum logic {
        RC_REMOVED = 1'b0,
        RC_ABSENT  = 1'b1
    } del_code_e;

    // Position recorded when a given state is entered; other states keep it.
    function automatic del_pos_e pos_on_entry(del_state_e s, del_pos_e cur);
        case (s)
            ST_NOHEAD:   return POS_NONE;
            ST_CUT_HEAD: return POS_HEAD;
            ST_CUT_MID:  return POS_MID;
            ST_CUT_TAIL: return POS_TAIL;
            ST_MISS:     return POS_MISS;
            default:     return cur;
        endcase
    endfunction

    function automatic logic ends_command(del_state_e s);
        return (s == ST_NOHEAD) || (s == ST_MISS) || (s == ST_WIPE);
    endfunction

endpackage

// File: rtl/cd_pos_track.sv
module cd_pos_track
    import chain_del_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  del_state_e state_q,
    input  del_state_e state_d,
    output del_pos_e   pos_o
);
    always_ff @(posedge clk) begin
        if (rst)
            pos_o <= POS_NONE;
        else if (state_d != state_q)
            pos_o <= pos_on_entry(state_d, pos_o);
    end
endmodule

// File: rtl/cd_pred_regs.sv
module cd_pred_regs #(
    parameter int KEY_W = 16,
    parameter int VAL_W = 8,
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,      // first node pointer taken from head entry
    input  logic             step,       // current node did not match, move on
    input  logic             hit,        // current node matched
    input  logic [PTR_W-1:0] head_ptr,
    input  logic [KEY_W-1:0] rd_key,
    input  logic [VAL_W-1:0] rd_val,
    input  logic [PTR_W-1:0] rd_next,
    input  logic             rd_nvld,
    output logic [PTR_W-1:0] cur_addr,
    output logic             prev_ok,
    output logic [PTR_W-1:0] prev_addr,
    output logic [KEY_W-1:0] prev_key,
    output logic [VAL_W-1:0] prev_val,
    output logic [PTR_W-1:0] hit_next,
    output logic             hit_nvld
);
    // Predecessor copy lives in its own registers, loaded only when the walk
    // advances, so a later read can never alias the node to be patched.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr  <= '0;
            prev_ok   <= 1'b0;
            prev_addr <= '0;
            prev_key  <= '0;
            prev_val  <= '0;
            hit_next  <= '0;
            hit_nvld  <= 1'b0;
        end else begin
            if (start) begin
                cur_addr <= head_ptr;
                prev_ok  <= 1'b0;
            end else if (step) begin
                prev_addr <= cur_addr;
                prev_key  <= rd_key;
                prev_val  <= rd_val;
                prev_ok   <= 1'b1;
                cur_addr  <= rd_next;
            end
            if (hit) begin
                hit_next <= rd_next;
                hit_nvld <= rd_nvld;
            end
        end
    end
endmodule

// File: rtl/chain_delete_engine.sv
module chain_delete_engine
    import chain_del_pkg::*;
#(
    parameter  int KEY_W   = 16,
    parameter  int VAL_W   = 8,
    parameter  int NODES   = 16,
    parameter  int BUCKETS = 8,
    localparam int PTR_W   = $clog2(NODES),
    localparam int BKT_W   = $clog2(BUCKETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [KEY_W-1:0] cmd_key,
    input  logic [BKT_W-1:0] cmd_bucket,
    output logic             head_rd_en,
    output logic [BKT_W-1:0] head_addr,
    input  logic [PTR_W-1:0] head_rd_ptr,
    input  logic             head_rd_vld,
    output logic             head_wr_en,
    output logic [PTR_W-1:0] head_wr_ptr,
    output logic             head_wr_vld,
    output logic             node_rd_en,
    output logic [PTR_W-1:0] node_rd_addr,
    input  logic [KEY_W-1:0] node_rd_key,
    input  logic [VAL_W-1:0] node_rd_val,
    input  logic [PTR_W-1:0] node_rd_next,
    input  logic             node_rd_nvld,
    output logic             node_wr_en,
    output logic [PTR_W-1:0] node_wr_addr,
    output logic [KEY_W-1:0] node_wr_key,
    output logic [VAL_W-1:0] node_wr_val,
    output logic [PTR_W-1:0] node_wr_next,
    output logic             node_wr_nvld,
    output logic             free_valid,
    output logic [PTR_W-1:0] free_ptr,
    output logic             res_valid,
    output logic             res_code,
    output logic [2:0]       res_pos,
    output logic [KEY_W-1:0] res_key
);
    del_state_e       state_q, state_d;
    del_pos_e         pos;
    logic [KEY_W-1:0] key_q;
    logic [BKT_W-1:0] bucket_q;
    logic             accept, key_hit, start, step, hit;
    logic [PTR_W-1:0] cur_addr, prev_addr, hit_next;
    logic [KEY_W-1:0] prev_key;
    logic [VAL_W-1:0] prev_val;
    logic             prev_ok, hit_nvld;
    logic             wiping;

    assign accept  = (state_q == ST_IDLE) && cmd_valid;
    assign key_hit = (node_rd_key == key_q);
    assign start   = (state_q == ST_HEADCHK) && head_rd_vld;
    assign step    = (state_q == ST_WALK) && !key_hit && node_rd_nvld;
    assign hit     = (state_q == ST_WALK) && key_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            key_q    <= '0;
            bucket_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                key_q    <= cmd_key;
                bucket_q <= cmd_bucket;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (cmd_valid) state_d = ST_HEADCHK;
            ST_HEADCHK: state_d = head_rd_vld ? ST_WALK : ST_NOHEAD;
            ST_WALK: begin
                if (key_hit) begin
                    if (!prev_ok)          state_d = ST_CUT_HEAD;
                    else if (node_rd_nvld) state_d = ST_CUT_MID;
                    else                   state_d = ST_CUT_TAIL;
                end else if (!node_rd_nvld) begin
                    state_d = ST_MISS;
                end
            end
            ST_CUT_HEAD, ST_CUT_MID, ST_CUT_TAIL: state_d = ST_WIPE;
            ST_NOHEAD, ST_MISS, ST_WIPE:          state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    cd_pred_regs #(.KEY_W(KEY_W), .VAL_W(VAL_W), .PTR_W(PTR_W)) u_pred (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .step     (step),
        .hit      (hit),
        .head_ptr (head_rd_ptr),
        .rd_key   (node_rd_key),
        .rd_val   (node_rd_val),
        .rd_next  (node_rd_next),
        .rd_nvld  (node_rd_nvld),
        .cur_addr (cur_addr),
        .prev_ok  (prev_ok),
        .prev_addr(prev_addr),
        .prev_key (prev_key),
        .prev_val (prev_val),
        .hit_next (hit_next),
        .hit_nvld (hit_nvld)
    );

    cd_pos_track u_pos (
        .clk    (clk),
        .rst    (rst),
        .state_q(state_q),
        .state_d(state_d),
        .pos_o  (pos)
    );

    assign cmd_ready  = (state_q == ST_IDLE);
    assign head_rd_en = accept;
    assign head_addr  = (state_q == ST_IDLE) ? cmd_bucket : bucket_q;

    assign node_rd_en   = start || step;
    assign node_rd_addr = (state_q == ST_HEADCHK) ? head_rd_ptr : node_rd_next;

    assign head_wr_en  = (state_q == ST_CUT_HEAD);
    assign head_wr_ptr = hit_nvld ? hit_next : '0;
    assign head_wr_vld = hit_nvld;

    assign wiping       = (state_q == ST_WIPE);
    assign node_wr_en   = wiping || (state_q == ST_CUT_MID) || (state_q == ST_CUT_TAIL);
    assign node_wr_addr = wiping ? cur_addr : prev_addr;
    assign node_wr_key  = wiping ? '0 : prev_key;
    assign node_wr_val  = wiping ? '0 : prev_val;
    assign node_wr_next = (wiping || !hit_nvld) ? '0 : hit_next;
    assign node_wr_nvld = !wiping && hit_nvld;

    assign free_valid = wiping;
    assign free_ptr   = cur_addr;

    assign res_valid = ends_command(state_q);
    assign res_code  = wiping ? RC_REMOVED : RC_ABSENT;
    assign res_pos   = pos;
    assign res_key   = key_q;
endmodule

// File: rtl/cd_delete_chk.sv
module cd_delete_chk #(
    parameter int KEY_W = 16,
    parameter int VAL_W = 8,
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             head_wr_en,
    input logic             node_wr_en,
    input logic [PTR_W-1:0] node_wr_addr,
    input logic [KEY_W-1:0] node_wr_key,
    input logic [VAL_W-1:0] node_wr_val,
    input logic [PTR_W-1:0] node_wr_next,
    input logic             node_wr_nvld,
    input logic             free_valid,
    input logic [PTR_W-1:0] free_ptr,
    input logic             res_valid,
    input logic             res_code,
    input logic [2:0]       res_pos
);
    logic busy_q;
    always_ff @(posedge clk) begin
        if (rst)                        busy_q <= 1'b0;
        else if (cmd_valid && cmd_ready) busy_q <= 1'b1;
        else if (res_valid)             busy_q <= 1'b0;
    end

    assert_ready_drops_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_ready);

    assert_result_has_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> busy_q);

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !busy_q);

    assert_absent_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_code |-> !free_valid && !node_wr_en && !head_wr_en);

    assert_absent_pos_R4: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_code |-> (res_pos == 3'd0) || (res_pos == 3'd4));

    assert_head_cut_R5: assert property (@(posedge clk) disable iff (rst)
        head_wr_en |=> free_valid && res_pos == 3'd1);

    assert_single_writer_R5: assert property (@(posedge clk) disable iff (rst)
        !(head_wr_en && node_wr_en));

    assert_mid_link_R6: assert property (@(posedge clk) disable iff (rst)
        node_wr_en && !free_valid && res_pos == 3'd2 |-> node_wr_nvld);

    assert_tail_link_R7: assert property (@(posedge clk) disable iff (rst)
        node_wr_en && !free_valid && res_pos == 3'd3 |-> !node_wr_nvld && node_wr_next == '0);

    assert_unlink_then_wipe_R9: assert property (@(posedge clk) disable iff (rst)
        node_wr_en && !free_valid |=> free_valid);

    assert_wipe_zero_R9: assert property (@(posedge clk) disable iff (rst)
        free_valid |-> node_wr_en && node_wr_addr == free_ptr && node_wr_key == '0
                       && node_wr_val == '0 && !node_wr_nvld && res_valid && !res_code);
endmodule

bind chain_delete_engine cd_delete_chk #(.KEY_W(KEY_W), .VAL_W(VAL_W), .PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .head_wr_en  (head_wr_en),
    .node_wr_en  (node_wr_en),
    .node_wr_addr(node_wr_addr),
    .node_wr_key (node_wr_key),
    .node_wr_val (node_wr_val),
    .node_wr_next(node_wr_next),
    .node_wr_nvld(node_wr_nvld),
    .free_valid  (free_valid),
    .free_ptr    (free_ptr),
    .res_valid   (res_valid),
    .res_code    (res_code),
    .res_pos     (res_pos)
);

// File: tb/tb_chain_delete_engine.sv
module tb_chain_delete_engine;
    localparam int KEY_W = 16, VAL_W = 8, NODES = 16, BUCKETS = 8;

    logic clk = 1'b0, rst = 1'b1;
    always #10 clk = ~clk;

    logic             cmd_valid = 1'b0, cmd_ready;
    logic [15:0]      cmd_key = '0;
    logic [2:0]       cmd_bucket = '0;
    logic             head_rd_en, head_wr_en, head_wr_vld, head_rd_vld;
    logic [2:0]       head_addr;
    logic [3:0]       head_rd_ptr, head_wr_ptr;
    logic             node_rd_en, node_wr_en, node_rd_nvld, node_wr_nvld;
    logic [3:0]       node_rd_addr, node_wr_addr, node_rd_next, node_wr_next;
    logic [15:0]      node_rd_key, node_wr_key, res_key;
    logic [7:0]       node_rd_val, node_wr_val;
    logic             free_valid, res_valid, res_code;
    logic [3:0]       free_ptr;
    logic [2:0]       res_pos;

    chain_delete_engine #(.KEY_W(KEY_W), .VAL_W(VAL_W), .NODES(NODES), .BUCKETS(BUCKETS)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_key(cmd_key), .cmd_bucket(cmd_bucket),
        .head_rd_en(head_rd_en), .head_addr(head_addr), .head_rd_ptr(head_rd_ptr),
        .head_rd_vld(head_rd_vld), .head_wr_en(head_wr_en), .head_wr_ptr(head_wr_ptr),
        .head_wr_vld(head_wr_vld), .node_rd_en(node_rd_en), .node_rd_addr(node_rd_addr),
        .node_rd_key(node_rd_key), .node_rd_val(node_rd_val), .node_rd_next(node_rd_next),
        .node_rd_nvld(node_rd_nvld), .node_wr_en(node_wr_en), .node_wr_addr(node_wr_addr),
        .node_wr_key(node_wr_key), .node_wr_val(node_wr_val), .node_wr_next(node_wr_next),
        .node_wr_nvld(node_wr_nvld), .free_valid(free_valid), .free_ptr(free_ptr),
        .res_valid(res_valid), .res_code(res_code), .res_pos(res_pos), .res_key(res_key)
    );

    // Table models, one-cycle read latency
    logic [15:0] mk [NODES];
    logic [7:0]  mv [NODES];
    logic [3:0]  mn [NODES];
    logic        mnv[NODES];
    logic [3:0]  hp [BUCKETS];
    logic        hv [BUCKETS];
    int          wr_cnt;

    always @(posedge clk) begin
        if (head_rd_en) begin
            head_rd_ptr <= hp[head_addr];
            head_rd_vld <= hv[head_addr];
        end
        if (node_rd_en) begin
            node_rd_key  <= mk[node_rd_addr];
            node_rd_val  <= mv[node_rd_addr];
            node_rd_next <= mn[node_rd_addr];
            node_rd_nvld <= mnv[node_rd_addr];
        end
        if (head_wr_en) begin
            hp[head_addr] = head_wr_ptr;
            hv[head_addr] = head_wr_vld;
            wr_cnt = wr_cnt + 1;
        end
        if (node_wr_en) begin
            mk[node_wr_addr]  = node_wr_key;
            mv[node_wr_addr]  = node_wr_val;
            mn[node_wr_addr]  = node_wr_next;
            mnv[node_wr_addr] = node_wr_nvld;
            wr_cnt = wr_cnt + 1;
        end
    end

    // Reference model
    int unsigned chain[BUCKETS][$];
    int unsigned free_q[$];
    logic [15:0] ref_k[NODES];
    logic [7:0]  ref_v[NODES];

    int checks = 0, errors = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_key(input int b, input int j);
        return {b[2:0], 5'd0, j[7:0]};
    endfunction

    function automatic int find_idx(input int b, input logic [15:0] k);
        foreach (chain[b][i]) if (ref_k[chain[b][i]] == k) return i;
        return -1;
    endfunction

    function automatic bit chain_ok(input int b);
        int n = chain[b].size();
        if (n == 0) return (hv[b] == 1'b0);
        if (!hv[b] || hp[b] != 4'(chain[b][0])) return 1'b0;
        for (int i = 0; i < n; i++) begin
            int unsigned s = chain[b][i];
            if (mk[s] != ref_k[s] || mv[s] != ref_v[s]) return 1'b0;
            if (i == n - 1) begin
                if (mnv[s]) return 1'b0;
            end else if (!mnv[s] || mn[s] != 4'(chain[b][i+1])) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic bench_insert(input int b, input int j);
        int unsigned s;
        logic [15:0] k = mk_key(b, j);
        if (free_q.size() == 0 || find_idx(b, k) >= 0) return;
        @(negedge clk);
        s = free_q.pop_front();
        ref_k[s] = k; ref_v[s] = 8'($urandom);
        mk[s] = k; mv[s] = ref_v[s]; mn[s] = '0; mnv[s] = 1'b0;
        if (chain[b].size() == 0) begin
            hp[b] = 4'(s); hv[b] = 1'b1;
        end else begin
            mn[chain[b][$]] = 4'(s); mnv[chain[b][$]] = 1'b1;
        end
        chain[b].push_back(s);
    endtask

    task automatic bench_delete(input int b, input int j, input string tag);
        logic [15:0] k = mk_key(b, j);
        int idx = find_idx(b, k);
        int n = chain[b].size();
        int exp_pos;
        int unsigned slot = 0;
        bit got = 1'b0;
        logic g_code, g_free;
        logic [2:0] g_pos;
        logic [3:0] g_fp;
        logic [15:0] g_key;
        if (n == 0) exp_pos = 0;
        else if (idx < 0) exp_pos = 4;
        else if (idx == 0) exp_pos = 1;
        else if (idx == n - 1) exp_pos = 3;
        else exp_pos = 2;
        if (idx >= 0) slot = chain[b][idx];

        @(negedge clk);
        wr_cnt = 0;
        check({tag, " R1 ready idle"}, cmd_ready == 1'b1, int'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_key = k; cmd_bucket = 3'(b);
        @(negedge clk);
        cmd_valid = 1'b0;
        check({tag, " R1 ready busy"}, cmd_ready == 1'b0, int'(cmd_ready), 0);
        for (int c = 0; c < 60 && !got; c++) begin
            if (res_valid) begin
                got = 1'b1;
                g_code = res_code; g_pos = res_pos; g_free = free_valid;
                g_fp = free_ptr; g_key = res_key;
            end else @(negedge clk);
        end
        check({tag, " R2 result seen"}, got, int'(got), 1);
        if (!got) return;
        check({tag, " R2 result key"}, g_key == k, int'(g_key), int'(k));
        @(negedge clk);
        check({tag, " R2 single result"}, res_valid == 1'b0 && cmd_ready, int'(res_valid), 0);
        check({tag, " position"}, int'(g_pos) == exp_pos, int'(g_pos), exp_pos);
        if (idx < 0) begin
            check({tag, (n == 0) ? " R3 code" : " R4 code"}, g_code == 1'b1, int'(g_code), 1);
            check({tag, (n == 0) ? " R3 no writes" : " R4 no writes"},
                  wr_cnt == 0 && !g_free, wr_cnt, 0);
        end else begin
            check({tag, " R9 code"}, g_code == 1'b0, int'(g_code), 0);
            check({tag, " R9 free slot"}, g_free && int'(g_fp) == int'(slot), int'(g_fp), int'(slot));
            check({tag, " R9 two writes"}, wr_cnt == 2, wr_cnt, 2);
            check({tag, " R9 slot zeroed"},
                  mk[slot] == '0 && mv[slot] == '0 && mn[slot] == '0 && !mnv[slot],
                  int'(mk[slot]), 0);
            chain[b].delete(idx);
            free_q.push_back(slot);
        end
        check({tag, " R8 chain intact"}, chain_ok(b), 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5021));
        for (int i = 0; i < NODES; i++) begin
            mk[i] = '0; mv[i] = '0; mn[i] = '0; mnv[i] = 1'b0;
            free_q.push_back(i);
        end
        for (int i = 0; i < BUCKETS; i++) begin hp[i] = '0; hv[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("reset R1 ready", cmd_ready == 1'b1, int'(cmd_ready), 1);
        check("reset R2 idle outputs",
              !res_valid && !free_valid && !head_wr_en && !node_wr_en, int'(res_valid), 0);

        bench_delete(5, 1, "empty bucket R3");
        bench_insert(1, 3);
        bench_delete(1, 3, "single node R5 R10");
        check("single node R5 head cleared", hv[1] == 1'b0 && hp[1] == '0, int'(hv[1]), 0);
        for (int j = 1; j <= 4; j++) bench_insert(2, j);
        bench_delete(2, 7, "walk miss R4");
        bench_delete(2, 2, "middle R6");
        bench_delete(2, 4, "tail R7");
        bench_delete(2, 1, "head with successor R5");
        for (int j = 1; j <= 6; j++) bench_insert(3, j);
        bench_delete(3, 5, "deep middle R8");
        bench_delete(3, 6, "deep tail R8");

        for (int it = 0; it < 600; it++) begin
            int b = (($urandom % 4) == 0) ? int'($urandom % BUCKETS) : int'($urandom % 2);
            int j = 1 + int'($urandom % 8);
            if (($urandom % 2) == 0) bench_insert(b, j);
            else bench_delete(b, j, "random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule